// File: doc/BRIEF.md
# Sixteen-Line GPIO and Control Register Block

This block sits on a simple synchronous register bus and holds a small bank of 16-bit registers: a mode word, configuration data and control words, a power word, three interrupt-related words kept as plain storage, and a fixed status word. Next to them it carries a 16-line general-purpose I/O unit made of a direction register and a level register. Sixteen external input lines can also set or clear bits of the level register.

Outputs are driven only for lines whose direction bit is set. The unit remembers the pattern it last drove. Whenever software writes the direction register or the level register, a two-state machine (`GS_IDLE`, `GS_EVAL`) moves from `GS_IDLE` to `GS_EVAL` on the write edge. In `GS_EVAL` it drives the new effective pattern and raises a one-cycle change strobe on each line whose driven value differs. It then returns to `GS_IDLE`, or stays in `GS_EVAL` if another direction or level write is accepted in that same cycle. Input-line updates change the level register only. The outputs follow them at the next bus write to direction or level.

Register offsets, decoded from address bits [5:0] only: 0x00 mode, 0x04 config data, 0x08 status, 0x0C power, 0x10 config control, 0x14 interrupt routing, 0x18 interrupt mask, 0x1C interrupt pending, 0x20 direction, 0x24 and 0x28 level.

Top module: `regbank_gpio16`

## Requirements
- R1: Only address bits [5:0] select a register. Addresses that differ only in higher bits reach the same register.
- R2: Write data is cut to its low 16 bits. The mode, config data, config control, interrupt routing, mask and pending words read back exactly the value last written to them.
- R3: A write to the power word stores the value. When bit 7 of that value is 1, bits 15 and 6 of the stored word are also set (0x0080 reads back as 0x80C0).
- R4: The status word reads 0x0002 and is unchanged by writes to offset 0x08.
- R5: Offsets 0x24 and 0x28 access one level register. A write to either stores the value ANDed with the current direction register, and a read of either returns the level register.
- R6: The cycle after a direction or level write takes effect, the outputs show level AND direction. Each line whose driven value changed pulses its strobe high for exactly one cycle.
- R7: Lines whose driven value does not change get no strobe. No strobe appears unless a direction or level write was accepted two edges earlier.
- R8: An input-line update (update bit i high with value bit) sets or clears level bit i on the next edge, for any line. The outputs stay unchanged until the next direction or level write.
- R9: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register.
- R10: When a bus level write and an input-line update fall in the same cycle, the bus write decides every bit of the level register.
- R11: After reset, every register reads 0 except status, and the outputs and strobes are 0.
- R12: Read data is 0 whenever read enable is low. When read enable is high, read data comes combinationally from the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | BUS_W | Write data, low 16 bits used |
| bus_rdata | output | 16 | Read data |
| pin_upd | input | 16 | Per-line input update request |
| pin_val | input | 16 | Per-line input value |
| pin_out | output | 16 | Driven output levels |
| pin_chg | output | 16 | Per-line one-cycle change strobe |

## Verification
Two functions can meet in one cycle. The first is a bus write to the level register coinciding with an input-line update. The second is a new direction or level write landing while the machine is still in `GS_EVAL`. The bench provokes the first by raising an update on a line in the same cycle as a level write that clears it, then reads the level back. It provokes the second with back-to-back direction and level writes. A behavioural model that re-evaluates the outputs only after such writes judges every clock's outputs, strobes and read data.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int REG_W   = 16;
    localparam int OFF_W   = 6;
    localparam int N_PLAIN = 6;

    localparam logic [REG_W-1:0] STATUS_VALUE = 16'h0002;
    localparam int               PWR_TRIG_BIT = 7;
    localparam logic [REG_W-1:0] PWR_FORCE    = 16'h8040;

    localparam logic [OFF_W-1:0] OFF_MODE = 6'h00;
    localparam logic [OFF_W-1:0] OFF_CFGD = 6'h04;
    localparam logic [OFF_W-1:0] OFF_STAT = 6'h08;
    localparam logic [OFF_W-1:0] OFF_PWR  = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_CFGC = 6'h10;
    localparam logic [OFF_W-1:0] OFF_IRT  = 6'h14;
    localparam logic [OFF_W-1:0] OFF_IMSK = 6'h18;
    localparam logic [OFF_W-1:0] OFF_IPND = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_DIR  = 6'h20;
    localparam logic [OFF_W-1:0] OFF_LVLW = 6'h24;
    localparam logic [OFF_W-1:0] OFF_LVLR = 6'h28;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_MODE, SEL_CFGD, SEL_STAT, SEL_PWR, SEL_CFGC,
        SEL_IRT, SEL_IMSK, SEL_IPND, SEL_DIR, SEL_LVLW, SEL_LVLR
    } reg_sel_e;

    typedef enum logic {
        GS_IDLE,
        GS_EVAL
    } gpio_state_e;

    localparam reg_sel_e PLAIN_SEL [N_PLAIN] = '{
        SEL_MODE, SEL_CFGD, SEL_CFGC, SEL_IRT, SEL_IMSK, SEL_IPND
    };

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output reg_sel_e         sel
);
    always_comb begin
        unique case (off)
            OFF_MODE: sel = SEL_MODE;
            OFF_CFGD: sel = SEL_CFGD;
            OFF_STAT: sel = SEL_STAT;
            OFF_PWR:  sel = SEL_PWR;
            OFF_CFGC: sel = SEL_CFGC;
            OFF_IRT:  sel = SEL_IRT;
            OFF_IMSK: sel = SEL_IMSK;
            OFF_IPND: sel = SEL_IPND;
            OFF_DIR:  sel = SEL_DIR;
            OFF_LVLW: sel = SEL_LVLW;
            OFF_LVLR: sel = SEL_LVLR;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/regbank_ctl.sv
module regbank_ctl
    import regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] pwr_q
);
    logic [REG_W-1:0] plain_rd [N_PLAIN];

    for (genvar gi = 0; gi < N_PLAIN; gi++) begin : g_plain
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && sel == PLAIN_SEL[gi])
                word_q <= wr_data;
        end
        assign plain_rd[gi] = (sel == PLAIN_SEL[gi]) ? word_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pwr_q <= '0;
        else if (wr_en && sel == SEL_PWR)
            pwr_q <= wr_data | (wr_data[PWR_TRIG_BIT] ? PWR_FORCE : '0);
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_PLAIN; i++)
            rd_data = rd_data | plain_rd[i];
        if (sel == SEL_PWR)
            rd_data = rd_data | pwr_q;
        if (sel == SEL_STAT)
            rd_data = rd_data | STATUS_VALUE;
    end
endmodule

// File: rtl/regbank_gpio.sv
module regbank_gpio
    import regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] in_upd,
    input  logic [REG_W-1:0] in_val,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] dir_q,
    output logic [REG_W-1:0] lvl_q,
    output logic [REG_W-1:0] out_q,
    output logic [REG_W-1:0] chg_q
);
    gpio_state_e      state_q, state_d;
    logic             dir_wr, lvl_wr, gpio_wr;
    logic [REG_W-1:0] eff;

    assign dir_wr  = wr_en && (sel == SEL_DIR);
    assign lvl_wr  = wr_en && (sel == SEL_LVLW || sel == SEL_LVLR);
    assign gpio_wr = dir_wr || lvl_wr;
    assign eff     = lvl_q & dir_q;

    // next-state logic
    always_comb begin
        unique case (state_q)
            GS_IDLE: state_d = gpio_wr ? GS_EVAL : GS_IDLE;
            GS_EVAL: state_d = gpio_wr ? GS_EVAL : GS_IDLE;
            default: state_d = GS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= GS_IDLE;
        else
            state_q <= state_d;
    end

    // output process: driven pattern and change strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            chg_q <= '0;
        end else begin
            unique case (state_q)
                GS_EVAL: begin
                    out_q <= eff;
                    chg_q <= eff ^ out_q;
                end
                default: chg_q <= '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dir_q <= '0;
        else if (dir_wr)
            dir_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (lvl_wr) begin
            lvl_q <= wr_data & dir_q;
        end else begin
            for (int i = 0; i < REG_W; i++)
                if (in_upd[i])
                    lvl_q[i] <= in_val[i];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DIR:           rd_data = dir_q;
            SEL_LVLW, SEL_LVLR: rd_data = lvl_q;
            default:           rd_data = '0;
        endcase
    end
endmodule

// File: rtl/regbank_gpio16.sv
module regbank_gpio16
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  pin_upd,
    input  logic [REG_W-1:0]  pin_val,
    output logic [REG_W-1:0]  pin_out,
    output logic [REG_W-1:0]  pin_chg
);
    reg_sel_e         sel;
    logic [REG_W-1:0] wr_data;
    logic [REG_W-1:0] ctl_rd, gpio_rd;
    logic [REG_W-1:0] pwr_q, dir_q, lvl_q;
    logic             unused_hi;

    assign wr_data   = bus_wdata[REG_W-1:0];
    assign unused_hi = ^{bus_addr[ADDR_W-1:OFF_W], bus_wdata[BUS_W-1:REG_W]};

    regbank_decode u_dec (
        .off (bus_addr[OFF_W-1:0]),
        .sel (sel)
    );

    regbank_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .sel     (sel),
        .wr_data (wr_data),
        .rd_data (ctl_rd),
        .pwr_q   (pwr_q)
    );

    regbank_gpio u_gpio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .sel     (sel),
        .wr_data (wr_data),
        .in_upd  (pin_upd),
        .in_val  (pin_val),
        .rd_data (gpio_rd),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .out_q   (pin_out),
        .chg_q   (pin_chg)
    );

    assign bus_rdata = bus_re ? (ctl_rd | gpio_rd) : '0;
endmodule

// File: rtl/regbank_gpio16_chk.sv
module regbank_gpio16_chk
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [REG_W-1:0]  pin_upd,
    input logic [REG_W-1:0]  pin_out,
    input logic [REG_W-1:0]  pin_chg,
    input logic [REG_W-1:0]  pwr_q,
    input logic [REG_W-1:0]  dir_q,
    input logic [REG_W-1:0]  lvl_q
);
    logic [OFF_W-1:0] off;
    logic             mapped, lvl_acc, gpio_acc;

    assign off      = bus_addr[OFF_W-1:0];
    assign mapped   = (off[1:0] == 2'b00) && (off <= OFF_LVLR);
    assign lvl_acc  = (off == OFF_LVLW) || (off == OFF_LVLR);
    assign gpio_acc = lvl_acc || (off == OFF_DIR);

    assert_power_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && off == OFF_PWR && bus_wdata[PWR_TRIG_BIT]
        |=> pwr_q[15] && pwr_q[6]);

    assert_status_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re && off == OFF_STAT |-> bus_rdata == STATUS_VALUE);

    assert_level_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && lvl_acc |=> (lvl_q & ~dir_q) == '0);

    assert_strobe_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_chg == (pin_out ^ $past(pin_out)));

    assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_chg != '0 |-> $past(bus_we && gpio_acc, 2));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re && !mapped |-> bus_rdata == '0);

    assert_bus_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && lvl_acc && pin_upd != '0
        |=> lvl_q == ($past(bus_wdata[REG_W-1:0]) & dir_q));

    assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> bus_rdata == '0);
endmodule

bind regbank_gpio16 regbank_gpio16_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_upd   (pin_upd),
    .pin_out   (pin_out),
    .pin_chg   (pin_chg),
    .pwr_q     (pwr_q),
    .dir_q     (dir_q),
    .lvl_q     (lvl_q)
);

// File: tb/sim_regbank_gpio16.sv
module sim_regbank_gpio16;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_we, bus_re;
    logic [31:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [15:0] pin_upd, pin_val, pin_out, pin_chg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regbank_gpio16 u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_upd(pin_upd), .pin_val(pin_val), .pin_out(pin_out), .pin_chg(pin_chg)
    );

    // behavioural reference model
    logic [15:0] m_word [16];
    logic [15:0] m_pwr, m_dir, m_lvl, m_out, m_stb;
    bit          m_pend;
    logic [5:0]  m_off;
    logic [15:0] m_wd;

    function automatic logic [15:0] model_read(input logic [5:0] o);
        case (o)
            6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C: return m_word[o[5:2]];
            6'h08: return 16'h0002;
            6'h0C: return m_pwr;
            6'h20: return m_dir;
            6'h24, 6'h28: return m_lvl;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_word[i] = 16'h0;
            m_pwr = 0; m_dir = 0; m_lvl = 0; m_out = 0; m_stb = 0; m_pend = 0;
        end else begin
            m_off = bus_addr[5:0];
            m_wd  = bus_wdata[15:0];
            if (m_pend) begin
                m_stb = (m_lvl & m_dir) ^ m_out;
                m_out = m_lvl & m_dir;
            end else begin
                m_stb = 16'h0;
            end
            m_pend = bus_we && (m_off == 6'h20 || m_off == 6'h24 || m_off == 6'h28);
            for (int i = 0; i < 16; i++)
                if (pin_upd[i]) m_lvl[i] = pin_val[i];
            if (bus_we) begin
                case (m_off)
                    6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C: m_word[m_off[5:2]] = m_wd;
                    6'h0C: m_pwr = m_wd[7] ? (m_wd | 16'h8040) : m_wd;
                    6'h20: m_dir = m_wd;
                    6'h24, 6'h28: m_lvl = m_wd & m_dir;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 model pin_out", pin_out, m_out);
            chk("R7 model pin_chg", pin_chg, m_stb);
            if (bus_re) chk("R2 model read", bus_rdata, model_read(bus_addr[5:0]));
            else        chk("R12 idle read", bus_rdata, 16'h0);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic pins(input logic [15:0] upd, input logic [15:0] val);
        pin_upd = upd; pin_val = val;
        @(posedge clk); #1;
        pin_upd = 16'h0;
    endtask

    // after a direction/level write: sample the cycle of the strobe
    task automatic expect_eval(input logic [15:0] out_e, input logic [15:0] chg_e, input string tag);
        @(posedge clk); @(negedge clk);
        chk({tag, " out"}, pin_out, out_e);
        chk({tag, " chg"}, pin_chg, chg_e);
        @(posedge clk); @(negedge clk);
        chk("R7 strobe one cycle", pin_chg, 16'h0);
        @(posedge clk); #1;
    endtask

    initial begin
        rst_n = 1'b0; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
        pin_upd = 0; pin_val = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R11 reset state
        chk("R11 reset pin_out", pin_out, 16'h0);
        chk("R11 reset pin_chg", pin_chg, 16'h0);
        rd(12'h000, 16'h0000, "R11 reset mode");
        rd(12'h020, 16'h0000, "R11 reset dir");
        rd(12'h008, 16'h0002, "R4 status reset");

        // R2 truncation and plain storage
        wr(12'h000, 32'hABCD1234);
        rd(12'h000, 16'h1234, "R2 mode truncated");
        wr(12'h010, 32'h0000BEEF); wr(12'h014, 32'h00001111);
        wr(12'h018, 32'h00002222); wr(12'h01C, 32'hFFFF3333);
        rd(12'h010, 16'hBEEF, "R2 cfg control");
        rd(12'h014, 16'h1111, "R2 irq routing");
        rd(12'h018, 16'h2222, "R2 irq mask");
        rd(12'h01C, 16'h3333, "R2 irq pending");

        // R3 power side effect
        wr(12'h00C, 32'h00000080);
        rd(12'h00C, 16'h80C0, "R3 power forced bits");
        wr(12'h00C, 32'h00000001);
        rd(12'h00C, 16'h0001, "R3 power plain");

        // R4 status ignores writes
        wr(12'h008, 32'h0000FFFF);
        rd(12'h008, 16'h0002, "R4 status after write");

        // R1 alias through high address bits
        wr(12'hFC4, 32'h00005A5A);
        rd(12'h004, 16'h5A5A, "R1 alias write");
        rd(12'h0C4, 16'h5A5A, "R1 alias read");

        // R9 unmapped offsets
        wr(12'h02C, 32'h0000FFFF);
        wr(12'h002, 32'h0000FFFF);
        rd(12'h02C, 16'h0000, "R9 unmapped read");
        rd(12'h000, 16'h1234, "R9 mode untouched");
        rd(12'h004, 16'h5A5A, "R9 cfg data untouched");

        // R5 level masked by direction
        wr(12'h024, 32'h0000FFFF);
        expect_eval(16'h0000, 16'h0000, "R7 no change");
        rd(12'h024, 16'h0000, "R5 level masked by zero dir");
        wr(12'h020, 32'h000000FF);
        expect_eval(16'h0000, 16'h0000, "R7 dir only");
        wr(12'h024, 32'h00001234);
        expect_eval(16'h0034, 16'h0034, "R6 first drive");
        wr(12'h028, 32'h00000030);
        expect_eval(16'h0030, 16'h0004, "R7 only changed line");
        rd(12'h024, 16'h0030, "R5 read via write offset");
        rd(12'h028, 16'h0030, "R5 read via read offset");

        // R8 input lines change level only
        pins(16'h0002, 16'h0002);
        rd(12'h028, 16'h0032, "R8 input sets bit");
        repeat (3) @(posedge clk);
        #1 chk("R8 outputs hold", pin_out, 16'h0030);
        pins(16'h8000, 16'h8000);
        rd(12'h024, 16'h8032, "R8 input on undriven line");
        wr(12'h020, 32'h000080FF);
        expect_eval(16'h8032, 16'h8002, "R8 re-evaluated");
        pins(16'h0010, 16'h0000);
        rd(12'h024, 16'h8022, "R8 input clears bit");

        // back-to-back writes while evaluating
        wr(12'h024, 32'h000000FF);
        wr(12'h020, 32'h0000000F);
        @(posedge clk); @(negedge clk);
        chk("R6 back-to-back second out", pin_out, 16'h000F);
        chk("R6 back-to-back second chg", pin_chg, 16'h00F0);
        @(posedge clk); #1;

        // R10 bus wins over input line
        bus_we = 1'b1; bus_addr = 12'h024; bus_wdata = 32'h00000001;
        pin_upd = 16'h000A; pin_val = 16'h000A;
        @(posedge clk); #1;
        bus_we = 1'b0; pin_upd = 16'h0;
        rd(12'h024, 16'h0001, "R10 bus write wins");

        // R12 idle read
        bus_addr = 12'h008;
        @(negedge clk);
        chk("R12 rdata with re low", bus_rdata, 16'h0000);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule